// File: doc/BRIEF.md
# Cascadable Presettable BCD Decade Counter

A four-bit synchronous counter that steps through the decimal digits 0 to 9 in 8421 code on the rising clock edge. From 9 it wraps to 0. A value can be preset from a four-bit data input through an active-low load control. The count can be cleared through an active-low reset. A build-time parameter makes that reset either asynchronous or synchronous.

Counting is gated by two enables that have different roles. The parallel enable only gates the stepping of the count. The trickle enable gates the stepping and also qualifies the terminal-count flag. The flag is decoded combinationally from the present count and the trickle enable. One stage's flag can therefore feed the next stage's trickle enable in the same cycle, so several digits form one wide synchronous decimal counter. All stages share the parallel enable.

The controls act in a fixed order of precedence on each edge: clear first, then load, then count, then hold. If a value from 10 to 15 has been loaded, the next count step returns the counter to 0, so it always gets back into the decimal sequence.

Top module: `bcd_decade_cnt`

## Requirements
- R1: When reset and load are inactive and both enables are high, each rising edge advances `cnt` by one through 0,1,...,9. From 9 the next edge gives 0.
- R2: With `ASYNC_RST`=1, `rst_n` low forces `cnt` to 0 at once, without waiting for a clock edge, whatever the other inputs are.
- R3: With `ASYNC_RST`=0, `rst_n` low has no effect on `cnt` until the next rising edge, which then sets `cnt` to 0. This clear wins over an active load and over both enables being high.
- R4: With reset inactive and `load_n` low, the next rising edge copies `din` into `cnt` (bit 0 is the least significant bit), whatever the values of `en_par` and `en_trk`.
- R5: With reset and load inactive, `cnt` holds its value across a rising edge whenever `en_par` or `en_trk` is low.
- R6: `tc` is 1 exactly when `en_trk` is 1 and `cnt` equals 9. It reacts to `en_trk` in the same cycle, it does not depend on `en_par`, and it is 0 in every other state, including 10 to 15.
- R7: After a value from 10 to 15 has been loaded, it holds while counting is disabled. The first count step then sets `cnt` to 0.
- R8: Two stages with a shared `en_par` form a two-digit counter when the low stage's `tc` drives the high stage's `en_trk`. The pair counts 00 to 99, and the high stage's `tc` is 1 only at 99. The next step wraps the pair to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all synchronous changes occur on its rising edge |
| rst_n | input | 1 | Active-low clear; asynchronous or synchronous according to `ASYNC_RST` |
| load_n | input | 1 | Active-low preset control |
| din | input | DIGIT_W | Preset value |
| en_par | input | 1 | Count enable that gates counting only |
| en_trk | input | 1 | Count enable that gates counting and qualifies `tc` |
| cnt | output | DIGIT_W | Present count |
| tc | output | 1 | Terminal-count flag, combinational |

## Verification
The bench goes after the 9-to-0 wrap. A counter that ran on through 10 to 15 would show a non-decimal value and leave the two-digit chain short of 99. It checks that `tc` stays high with `en_par` low and drops as soon as `en_trk` falls. A flag gated by the wrong enable, or registered, would break the cascade. It presets illegal values 12 and 15 and then counts once. A design that simply incremented would show 13 or wrap through 15. It also probes both reset variants between clock edges. An asynchronous clear that waited for the edge, or a synchronous clear that acted at once or lost to a simultaneous load, shows up at once in the count.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
   // Action applied to the count on the next rising edge
   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_INC  = 2'd1,
      OP_LOAD = 2'd2,
      OP_CLR  = 2'd3
   } cnt_op_e;
endpackage

// File: rtl/bcd_cnt_mode.sv
module bcd_cnt_mode
   import bcd_cnt_pkg::*;
(
   input  logic    sclr,
   input  logic    load_n,
   input  logic    en_par,
   input  logic    en_trk,
   output cnt_op_e op
);
   // fixed precedence: clear, load, count, hold
   always_comb begin
      if (sclr)                  op = OP_CLR;
      else if (!load_n)          op = OP_LOAD;
      else if (en_par && en_trk) op = OP_INC;
      else                       op = OP_HOLD;
   end
endmodule

// File: rtl/bcd_cnt_next.sv
module bcd_cnt_next
   import bcd_cnt_pkg::*;
#(
   parameter int DIGIT_W  = 4,
   parameter int LAST_VAL = 9
) (
   input  cnt_op_e              op,
   input  logic [DIGIT_W-1:0]   cur,
   input  logic [DIGIT_W-1:0]   din,
   output logic [DIGIT_W-1:0]   nxt
);
   localparam logic [DIGIT_W-1:0] LAST = DIGIT_W'(LAST_VAL);

   logic [DIGIT_W-1:0] step;

   // any state at or above the terminal value re-enters at zero
   assign step = (cur >= LAST) ? '0 : cur + DIGIT_W'(1);

   always_comb begin
      unique case (op)
         OP_CLR:  nxt = '0;
         OP_LOAD: nxt = din;
         OP_INC:  nxt = step;
         default: nxt = cur;
      endcase
   end
endmodule

// File: rtl/bcd_cnt_reg.sv
module bcd_cnt_reg #(
   parameter int DIGIT_W = 4
) (
   input  logic               clk,
   input  logic               arst_n,
   input  logic [DIGIT_W-1:0] d,
   output logic [DIGIT_W-1:0] q
);
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) q <= '0;
      else         q <= d;
   end
endmodule

// File: rtl/bcd_cnt_tc.sv
module bcd_cnt_tc #(
   parameter int DIGIT_W  = 4,
   parameter int LAST_VAL = 9
) (
   input  logic [DIGIT_W-1:0] cur,
   input  logic               en_trk,
   output logic               tc
);
   localparam logic [DIGIT_W-1:0] LAST = DIGIT_W'(LAST_VAL);

   // full decode: high only in the terminal state
   assign tc = en_trk & (cur == LAST);
endmodule

// File: rtl/bcd_decade_cnt.sv
module bcd_decade_cnt
   import bcd_cnt_pkg::*;
#(
   parameter int DIGIT_W   = 4,
   parameter int LAST_VAL  = 9,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_n,
   input  logic [DIGIT_W-1:0] din,
   input  logic               en_par,
   input  logic               en_trk,
   output logic [DIGIT_W-1:0] cnt,
   output logic               tc
);
   // elaboration-time parameter checks
   if (DIGIT_W < 1) begin : g_bad_width
      $error("bcd_decade_cnt: DIGIT_W must be at least 1");
   end
   if (LAST_VAL < 1 || LAST_VAL >= (1 << DIGIT_W)) begin : g_bad_last
      $error("bcd_decade_cnt: LAST_VAL must fit in DIGIT_W bits and be nonzero");
   end

   logic               arst_n;
   logic               sclr;
   cnt_op_e            op;
   logic [DIGIT_W-1:0] nxt;

   // reset variant: route rst_n to the flop clear or to the next-state path
   if (ASYNC_RST) begin : g_arst
      assign arst_n = rst_n;
      assign sclr   = 1'b0;
   end else begin : g_srst
      assign arst_n = 1'b1;
      assign sclr   = ~rst_n;
   end

   bcd_cnt_mode u_mode (
      .sclr   (sclr),
      .load_n (load_n),
      .en_par (en_par),
      .en_trk (en_trk),
      .op     (op)
   );

   bcd_cnt_next #(.DIGIT_W(DIGIT_W), .LAST_VAL(LAST_VAL)) u_next (
      .op  (op),
      .cur (cnt),
      .din (din),
      .nxt (nxt)
   );

   bcd_cnt_reg #(.DIGIT_W(DIGIT_W)) u_reg (
      .clk    (clk),
      .arst_n (arst_n),
      .d      (nxt),
      .q      (cnt)
   );

   bcd_cnt_tc #(.DIGIT_W(DIGIT_W), .LAST_VAL(LAST_VAL)) u_tc (
      .cur    (cnt),
      .en_trk (en_trk),
      .tc     (tc)
   );
endmodule

// File: rtl/bcd_cnt_chk.sv
module bcd_cnt_chk #(
   parameter int DIGIT_W   = 4,
   parameter int LAST_VAL  = 9,
   parameter bit ASYNC_RST = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               load_n,
   input logic [DIGIT_W-1:0] din,
   input logic               en_par,
   input logic               en_trk,
   input logic [DIGIT_W-1:0] cnt,
   input logic               tc
);
   localparam logic [DIGIT_W-1:0] LAST = DIGIT_W'(LAST_VAL);

   AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> cnt == '0);                                                // R2 R3
   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      !load_n |=> cnt == $past(din));                                              // R4
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && en_par && en_trk && cnt < LAST) |=> cnt == $past(cnt) + DIGIT_W'(1)); // R1
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && en_par && en_trk && cnt == LAST) |=> cnt == '0);                 // R1
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !(en_par && en_trk)) |=> $stable(cnt));                          // R5
   AST_TC_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> (cnt == LAST && en_trk));                                             // R6
   AST_ILLEGAL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt > LAST && load_n && en_par && en_trk) |=> cnt == '0);                  // R7
   AST_ILLEGAL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt > LAST) |-> $past(cnt > LAST || !load_n));                              // R7
endmodule

bind bcd_decade_cnt bcd_cnt_chk #(
   .DIGIT_W(DIGIT_W), .LAST_VAL(LAST_VAL), .ASYNC_RST(ASYNC_RST)
) u_chk (
   .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
   .en_par(en_par), .en_trk(en_trk), .cnt(cnt), .tc(tc)
);

// File: tb/test_bcd_decade_cnt.sv
module test_bcd_decade_cnt;
   timeunit 1ns;
   timeprecision 1ps;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_n = 1'b1;
   logic [3:0] din = '0;
   logic       en_par = 1'b0;
   logic       en_trk = 1'b0;
   logic [3:0] cnt_a, cnt_s;
   logic       tc_a, tc_s;

   // two-stage chain
   logic       crst_n = 1'b0;
   logic       ch_ep = 1'b1;
   logic [3:0] c_lo, c_hi;
   logic       tc_lo, tc_hi;

   typedef struct { logic [3:0] exp; string tag; } item_t;
   item_t q[$];
   item_t it;
   int n_run = 0, n_fail = 0;
   logic [3:0] m = '0;

   always #4 clk = ~clk;   // 125 MHz

   bcd_decade_cnt #(.ASYNC_RST(1'b1)) i_bcd_decade_cnt (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
      .en_par(en_par), .en_trk(en_trk), .cnt(cnt_a), .tc(tc_a));

   bcd_decade_cnt #(.ASYNC_RST(1'b0)) i_sync_dut (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
      .en_par(en_par), .en_trk(en_trk), .cnt(cnt_s), .tc(tc_s));

   bcd_decade_cnt #(.ASYNC_RST(1'b0)) i_lo (
      .clk(clk), .rst_n(crst_n), .load_n(1'b1), .din(4'd0),
      .en_par(ch_ep), .en_trk(1'b1), .cnt(c_lo), .tc(tc_lo));

   bcd_decade_cnt #(.ASYNC_RST(1'b0)) i_hi (
      .clk(clk), .rst_n(crst_n), .load_n(1'b1), .din(4'd0),
      .en_par(ch_ep), .en_trk(tc_lo), .cnt(c_hi), .tc(tc_hi));

   task automatic chk(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // driver: apply one cycle of stimulus, check tc now, queue the count expected after the edge
   task automatic step(logic rs, logic ld, logic [3:0] d, logic ep, logic et, string tag);
      logic [3:0] nxt;
      @(negedge clk);
      rst_n = rs; load_n = ld; din = d; en_par = ep; en_trk = et;
      #1;
      chk({"R6 tc async (", tag, ")"}, tc_a, (et && m == 4'd9));
      chk({"R6 tc sync (", tag, ")"},  tc_s, (et && m == 4'd9));
      if (!rs)            nxt = 4'd0;
      else if (!ld)       nxt = d;
      else if (ep && et)  nxt = (m >= 4'd9) ? 4'd0 : m + 4'd1;
      else                nxt = m;
      q.push_back('{nxt, tag});
      m = nxt;
   endtask

   // monitor: compare both instances after each edge
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         it = q.pop_front();
         chk({it.tag, " async inst"}, cnt_a, it.exp);
         chk({it.tag, " sync inst"},  cnt_s, it.exp);
      end
   end

   initial begin
      #1ms;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R2 reset state async", cnt_a, 0);
      chk("R3 reset state sync",  cnt_s, 0);
      rst_n = 1'b1;

      // R1: full sequence with wrap
      for (int i = 0; i < 12; i++) step(1, 1, 4'd0, 1, 1, "R1 count");

      // R5: hold with either enable low
      step(1, 1, 4'd0, 0, 1, "R5 hold par low");
      step(1, 1, 4'd0, 1, 0, "R5 hold trk low");
      step(1, 1, 4'd0, 0, 0, "R5 hold both low");

      // R4 load, R6 tc independent of en_par
      step(1, 0, 4'd9, 0, 0, "R4 load 9");
      step(1, 1, 4'd0, 0, 1, "R6 at 9 par low");
      step(1, 1, 4'd0, 1, 0, "R6 at 9 trk low");
      step(1, 0, 4'd5, 1, 1, "R4 load over count");
      step(1, 1, 4'd0, 1, 1, "R4 count after load");

      // R7: illegal presets
      step(1, 0, 4'd12, 1, 1, "R7 load 12");
      step(1, 1, 4'd0, 0, 1, "R7 hold 12");
      step(1, 1, 4'd0, 1, 1, "R7 exit 12");
      step(1, 0, 4'd15, 0, 0, "R7 load 15");
      step(1, 1, 4'd0, 1, 1, "R7 exit 15");

      // R3: clear beats load and count
      step(1, 0, 4'd3, 1, 1, "R4 load 3");
      step(0, 0, 4'd7, 1, 1, "R3 clear beats load");
      step(1, 0, 4'd6, 0, 0, "R4 load 6");
      step(1, 1, 4'd0, 0, 0, "R5 hold 6");
      @(posedge clk); #3;

      // R2/R3: reset asserted between edges
      @(negedge clk); #1;
      rst_n = 1'b0;
      #1;
      chk("R2 async clears at once", cnt_a, 0);
      chk("R3 sync waits for edge",  cnt_s, 6);
      @(posedge clk); #2;
      chk("R3 sync clears on edge",  cnt_s, 0);
      @(negedge clk);
      rst_n = 1'b1;
      m = 4'd0;

      // R8: two-digit chain
      @(negedge clk);
      crst_n = 1'b1;
      #1;
      chk("R8 chain start", int'(c_hi) * 10 + int'(c_lo), 0);
      for (int k = 1; k <= 100; k++) begin
         @(posedge clk); #2;
         chk("R8 chain value", int'(c_hi) * 10 + int'(c_lo), k % 100);
         chk("R8 chain high tc", tc_hi, (k % 100 == 99));
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule